// File: doc/BRIEF.md
# DRAM Write Command Sequencer

This block sits on the controller side of a graphics DRAM. It takes write requests from the host and turns them into write commands on the memory pins, one request per command. Each request names a bank, a column and whether the row should close by itself once the write is done. The sequencer spaces the commands so that the write bursts follow one another without a break. For each bank it also tracks whether the row is open, how long ago it was activated and how far write recovery has progressed.

For every bank the sequencer reports two things. One flag says when an explicit precharge would now be legal. A one-cycle pulse marks the cycle in which the bank's own auto-precharge starts. When the write recovery ends before the minimum row-active time, that pulse is held back. Activates are issued by other logic, which reports each one with a pulse and the bank number. Burst length, write latency, write recovery and the minimum row-active time are static settings. They are copied into the block only while it has nothing in flight.

Cycle numbering used below: cycle 0 is the cycle in which a write command is on the pins. N = WL + BL/2 + tWR is the write recovery span, taken from the settings that were in force when the request was accepted.

Top module: `wr_cmd_seq`

## Requirements
- R1: While reset is asserted, cke is low, cs_n is high, req_ready is low, and every bit of pre_ok and ap_fire is low. From the first clock after reset, cke is high.
- R2: A write command is driven as {cs_n,ras_n,cas_n,we_n} = 0100. Every other cycle after reset carries a NOP, which is 0111, with ba and addr at zero.
- R3: During a write, ba carries the bank. Column bits 2..7 go to addr[2..7] and column bit 8 goes to addr[9]. addr[1:0] is driven as zero whatever the column, the auto-precharge flag sits on addr[8], and addr[11:10] are zero.
- R4: Two write commands are at least BL/2 cycles apart. With BL=4 and a request held continuously, there is exactly one NOP between consecutive writes.
- R5: req_ready is high only when the requested bank is open and the command gap has elapsed. A request to a closed bank stalls.
- R6: pre_ok of a bank is high exactly when the bank is open, cycle N after its last write has been reached, and tRAS(min) has elapsed.
- R7: After a write with auto-precharge, if tRAS(min) has elapsed by cycle N, ap_fire of that bank pulses for one cycle, in cycle N.
- R8: If tRAS(min) is met only in some cycle R later than cycle N, the ap_fire pulse comes in cycle R+1 instead.
- R9: A write with auto-precharge closes its bank. After it, pre_ok stays low and the bank accepts no write until the next activate.
- R10: An activate pulse (act_done with act_bank) opens that bank. tRAS(min) counts as met cfg_tras cycles after the cycle following the pulse.
- R11: The settings are copied only in cycles with no command gap pending, no write recovery running and no auto-precharge pending. A change made while the block is busy has no effect until it goes idle.
- R12: cfg_bl8 = 1 selects burst length 8, which makes the write spacing 4 cycles and adds 4 cycles, not 2, to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cfg_wl | input | 4 | Write latency in cycles |
| cfg_twr | input | 4 | Write recovery in cycles |
| cfg_tras | input | 5 | Minimum row-active time in cycles |
| act_done | input | 1 | Pulse: an activate was issued |
| act_bank | input | 3 | Bank of that activate |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The request is taken in this cycle |
| req_bank | input | 3 | Request bank |
| req_col | input | 9 | Request column |
| req_ap | input | 1 | Request auto-precharge |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | 12 | Address pins: column bits and auto-precharge flag |
| pre_ok | output | 8 | Per bank: an explicit precharge is legal |
| ap_fire | output | 8 | Per bank: the auto-precharge starts this cycle |

## Verification
A bank's recovery counter or activate timer that holds a wrong value shows up on pre_ok of that bank. The error is visible in the very cycle where the flag should rise or fall, which is at most N or tRAS cycles after the write or activate that loaded the counter. A wrong deferral decision moves the ap_fire pulse by one cycle or more, so any slip of a single cycle is seen at once. A wrong gap count or open flag changes req_ready in the same cycle, and from there the position of the next write on the command pins. A configuration copied while the block is busy changes the spacing or the recovery span of the very next write.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int WL_W   = 4;
  localparam int TWR_W  = 4;
  localparam int TRAS_W = 5;
  localparam int GAP_W  = 3;
  localparam int CNT_W  = 6;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_WR    = 4'b0100,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } cmd_e;

  typedef struct packed {
    logic              bl8;
    logic [WL_W-1:0]   wl;
    logic [TWR_W-1:0]  twr;
    logic [TRAS_W-1:0] tras;
  } cfg_t;

  // clock cycles occupied by one data burst
  function automatic logic [GAP_W-1:0] burst_clks(input logic bl8);
    return bl8 ? GAP_W'(4) : GAP_W'(2);
  endfunction

  // value loaded into the gap counter on a write
  function automatic logic [GAP_W-1:0] gap_load(input logic bl8);
    return burst_clks(bl8) - GAP_W'(1);
  endfunction

  // cycles from the write command to the end of write recovery
  function automatic logic [CNT_W-1:0] recov_total(input cfg_t c);
    return CNT_W'(c.wl) + CNT_W'(burst_clks(c.bl8)) + CNT_W'(c.twr);
  endfunction
endpackage

// File: rtl/wcs_cfg_gap.sv
module wcs_cfg_gap
  import wcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_in,
  input  logic accept,
  input  logic all_quiet,
  output cfg_t cfg_q,
  output logic gap_zero
);
  logic [GAP_W-1:0] gap_q;
  logic             idle_w;

  assign gap_zero = (gap_q == '0);
  assign idle_w   = gap_zero & all_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      cfg_q <= '0;
    end else begin
      if (accept)         gap_q <= gap_load(cfg_q.bl8);
      else if (!gap_zero) gap_q <= gap_q - GAP_W'(1);
      if (idle_w)         cfg_q <= cfg_in;
    end
  end

  // R4
  gap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> gap_zero);
endmodule

// File: rtl/wcs_bank_timer.sv
module wcs_bank_timer
  import wcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [TRAS_W-1:0] tras_ld,
  input  logic              wr,
  input  logic              wr_ap,
  input  logic [CNT_W-1:0]  rec_ld,
  output logic              open_o,
  output logic              quiet_o,
  output logic              pre_ok_o,
  output logic              ap_fire_o
);
  logic [TRAS_W-1:0] ras_q;
  logic [CNT_W-1:0]  rec_q;
  logic              ras_zero, rec_zero, ras_zero_d;
  logic              pend_q, late_q;

  assign ras_zero  = (ras_q == '0);
  assign rec_zero  = (rec_q == '0);
  // late precharge waits one cycle past the tRAS point
  assign ap_fire_o = pend_q & rec_zero & ras_zero & (!late_q | ras_zero_d);
  assign pre_ok_o  = open_o & rec_zero & ras_zero;
  assign quiet_o   = rec_zero & !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q      <= '0;
      rec_q      <= '0;
      ras_zero_d <= 1'b1;
      open_o     <= 1'b0;
      pend_q     <= 1'b0;
      late_q     <= 1'b0;
    end else begin
      ras_zero_d <= ras_zero;
      if (act)            ras_q <= tras_ld;
      else if (!ras_zero) ras_q <= ras_q - TRAS_W'(1);
      if (wr)             rec_q <= rec_ld;
      else if (!rec_zero) rec_q <= rec_q - CNT_W'(1);
      if (act)            open_o <= 1'b1;
      else if (wr && wr_ap) open_o <= 1'b0;
      if (wr && wr_ap)    pend_q <= 1'b1;
      else if (ap_fire_o) pend_q <= 1'b0;
      if (ap_fire_o || wr) late_q <= 1'b0;
      else if (pend_q && rec_zero && !ras_zero) late_q <= 1'b1;
    end
  end

  // R8
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && rec_zero && !ras_zero) |=> !ap_fire_o);
  // R9
  ap_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !open_o);
  // R7
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire_o |=> !ap_fire_o);
endmodule

// File: rtl/wcs_cmd_out.sv
module wcs_cmd_out
  import wcs_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic              ap,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);
  cmd_e cmd_q;

  // column bits skip the flag bit; the two lowest are forced to zero
  function automatic logic [ADDR_W-1:0] map_addr(input logic [COL_W-1:0] c, input logic a);
    logic [ADDR_W-1:0] r;
    r = '0;
    for (int i = 2; i < COL_W; i++) begin
      if (i < AP_BIT) r[i] = c[i];
      else            r[i+1] = c[i];
    end
    r[AP_BIT] = a;
    return r;
  endfunction

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke   <= 1'b0;
      cmd_q <= CMD_DESEL;
      ba    <= '0;
      addr  <= '0;
    end else begin
      cke   <= 1'b1;
      cmd_q <= issue ? CMD_WR : CMD_NOP;
      ba    <= issue ? bank : '0;
      addr  <= issue ? map_addr(col, ap) : '0;
    end
  end

  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> (cmd_q == CMD_WR || cmd_q == CMD_NOP));
  // R4
  nop_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |=> (cmd_q == CMD_NOP));
  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_WR) |-> (addr[1:0] == 2'b00));
endmodule

// File: rtl/wr_cmd_seq.sv
module wr_cmd_seq
  import wcs_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_bl8,
  input  logic [WL_W-1:0]          cfg_wl,
  input  logic [TWR_W-1:0]         cfg_twr,
  input  logic [TRAS_W-1:0]        cfg_tras,
  input  logic                     act_done,
  input  logic [BANK_W-1:0]        act_bank,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [BANK_W-1:0]        req_bank,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_ap,
  output logic                     cke,
  output logic                     cs_n,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [BANK_W-1:0]        ba,
  output logic [ADDR_W-1:0]        addr,
  output logic [(1<<BANK_W)-1:0]   pre_ok,
  output logic [(1<<BANK_W)-1:0]   ap_fire
);
  localparam int NBANK = 1 << BANK_W;

  cfg_t             cfg_in, cfg_q;
  logic             gap_zero, accept;
  logic [NBANK-1:0] open_vec, quiet_vec;
  logic [CNT_W-1:0] rec_ld;

  assign cfg_in    = '{cfg_bl8, cfg_wl, cfg_twr, cfg_tras};
  assign req_ready = gap_zero & open_vec[req_bank];
  assign accept    = req_valid & req_ready;
  assign rec_ld    = recov_total(cfg_q);

  wcs_cfg_gap u_gap (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .accept(accept),
    .all_quiet(&quiet_vec), .cfg_q(cfg_q), .gap_zero(gap_zero)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    wcs_bank_timer u_tmr (
      .clk(clk), .rst_n(rst_n),
      .act(act_done && (act_bank == BANK_W'(g))),
      .tras_ld(cfg_q.tras),
      .wr(accept && (req_bank == BANK_W'(g))),
      .wr_ap(req_ap), .rec_ld(rec_ld),
      .open_o(open_vec[g]), .quiet_o(quiet_vec[g]),
      .pre_ok_o(pre_ok[g]), .ap_fire_o(ap_fire[g])
    );
  end

  wcs_cmd_out #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_out (
    .clk(clk), .rst_n(rst_n), .issue(accept), .bank(req_bank), .col(req_col),
    .ap(req_ap), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr)
  );

  // R9
  closed_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ap_fire) |-> ((ap_fire & open_vec) == '0));
endmodule

// File: tb/tb_wr_cmd_seq.sv
module tb_wr_cmd_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_bl8 = 0; logic [3:0] cfg_wl = 3, cfg_twr = 4; logic [4:0] cfg_tras = 10;
  logic act_done = 0; logic [2:0] act_bank = 0;
  logic req_valid = 0, req_ready, req_ap = 0; logic [2:0] req_bank = 0; logic [8:0] req_col = 0;
  logic cke, cs_n, ras_n, cas_n, we_n; logic [2:0] ba; logic [11:0] addr;
  logic [7:0] pre_ok, ap_fire;

  always #4 clk = ~clk;

  wr_cmd_seq dut (.*);

  int nchk = 0, nfail = 0, k = 0, nrdy = 0;
  int done_m[8], rasok_m[8], fire_m[8]; bit open_m[8];
  bit sh_bl8 = 0; int sh_wl = 0, sh_twr = 0, sh_tras = 0;
  bit exp_wr = 0, exp_ap = 0, rdy_e = 0; int exp_bank = 0, exp_col = 0;
  string cur = "R1";
  bit finished = 0;

  task automatic chk(string rq, string nm, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", rq, nm, k, got, exp);
    end
  endtask

  function automatic logic [11:0] amap(int c, bit a);
    logic [11:0] r = 0;
    for (int i = 2; i < 9; i++) r[(i < 8) ? i : i + 1] = c[i];
    r[8] = a;
    return r;
  endfunction

  task automatic compare();
    logic [7:0] pe = 0, fe = 0;
    for (int b = 0; b < 8; b++) begin
      pe[b] = open_m[b] && k >= done_m[b] && k >= rasok_m[b];
      fe[b] = (k == fire_m[b]);
    end
    chk(cur, "cke", cke, 1);
    chk(cur, "cmd", {cs_n, ras_n, cas_n, we_n}, exp_wr ? 4'b0100 : 4'b0111);
    chk(cur, "ba", ba, exp_wr ? exp_bank : 0);
    chk(cur, "addr", addr, exp_wr ? amap(exp_col, exp_ap) : 0);
    chk(cur, "pre_ok", pre_ok, pe);
    chk(cur, "ap_fire", ap_fire, fe);
  endtask

  task automatic step(bit v, int b, int c, bit a, bit ac, int ab);
    bit idle, acc; int g;
    req_valid = v; req_bank = 3'(b); req_col = 9'(c); req_ap = a;
    act_done = ac; act_bank = 3'(ab);
    #1;
    rdy_e = (k >= nrdy) && open_m[b];
    if (k > 0) compare();
    chk(cur, "ready", req_ready, rdy_e);
    idle = (k >= nrdy);
    for (int i = 0; i < 8; i++) if (k < done_m[i] || k <= fire_m[i]) idle = 0;
    acc = v && rdy_e;
    exp_wr = acc; exp_bank = b; exp_col = c; exp_ap = a;
    if (acc) begin
      g = sh_bl8 ? 4 : 2;
      nrdy = k + g;
      done_m[b] = k + 1 + sh_wl + g + sh_twr;
      if (a) begin
        open_m[b] = 0;
        fire_m[b] = (done_m[b] >= rasok_m[b]) ? done_m[b] : rasok_m[b] + 1;
      end
    end
    if (ac) begin rasok_m[ab] = k + 1 + sh_tras; open_m[ab] = 1; end
    if (idle) begin sh_bl8 = cfg_bl8; sh_wl = cfg_wl; sh_twr = cfg_twr; sh_tras = cfg_tras; end
    k++;
    @(negedge clk);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin done_m[i] = 0; rasok_m[i] = 0; fire_m[i] = -1; open_m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cke", cke, 0);
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "ready", req_ready, 0);
    chk("R1", "pre_ok", pre_ok, 0);
    chk("R1", "ap_fire", ap_fire, 0);
    rst_n = 1;
    cur = "R1 R2"; idle_n(3);
    cur = "R10"; step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 1); idle_n(12);
    cur = "R3 R4";
    for (int i = 0; i < 10; i++) step(1, i % 2, 9'h1FF - i * 37, 0, 0, 0);
    cur = "R5"; for (int i = 0; i < 6; i++) step(1, 5, 3, 0, 0, 0);
    cur = "R6"; idle_n(20);
    cur = "R8 R9"; step(0, 0, 0, 0, 1, 2); step(1, 2, 9'h0AB, 1, 0, 0); idle_n(25);
    for (int i = 0; i < 4; i++) step(1, 2, 1, 0, 0, 0);
    cur = "R7"; step(0, 0, 0, 0, 1, 3); idle_n(15); step(1, 3, 9'h155, 1, 0, 0); idle_n(15);
    cur = "R12"; cfg_bl8 = 1; cfg_wl = 2; cfg_twr = 6; idle_n(2);
    for (int i = 0; i < 12; i++) step(1, i % 2, i * 11, 0, 0, 0);
    cur = "R11"; cfg_bl8 = 0; cfg_twr = 1;
    for (int i = 0; i < 12; i++) step(1, i % 2, i * 5, 0, 0, 0);
    idle_n(30);
    for (int i = 0; i < 6; i++) step(1, 0, i, 0, 0, 0);
    cur = "R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      int ab = $urandom_range(0, 7);
      bit ac = ($urandom_range(0, 9) == 0) && !open_m[ab] && (k > fire_m[ab]);
      if (i % 600 == 0) begin
        cfg_bl8 = 1'($urandom_range(0, 1)); cfg_wl = 4'($urandom_range(1, 15));
        cfg_twr = 4'($urandom_range(0, 15)); cfg_tras = 5'($urandom_range(0, 31));
      end
      step($urandom_range(0, 2) != 0, $urandom_range(0, 7), $urandom_range(0, 511),
           $urandom_range(0, 3) == 0, ac, ab);
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1; nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule